// File: doc/BRIEF.md
# Exception Level and Security State Tracker

This block holds the current exception level (EL0 to EL3) of a processing element, together with a secure configuration register whose bit 0 is the non-secure select. It accepts exception-entry and exception-return requests, each carrying a target level. It applies only the legal moves and flags the illegal ones. From the level and the configuration register it derives the effective security state.

For each outgoing bus access it also produces the AXI AxPROT[0] privilege bit and the AxPROT[1] non-secure bit. The privilege bit depends on the access class and the access direction as well as on the level. For this reason, cacheable traffic, table walks and some EL0 writes are marked privileged. The level readback is a read-only field with no write path into the block.

Top module: `elsec_tracker`

## Requirements
- R1: While reset is asserted and after it is released, the level is EL3 (code 3), the configuration register is all zero, and both illegal flags are 0.
- R2: An entry request whose target is greater than or equal to the current level sets the level to the target at the next clock edge. A target below the current level leaves the level unchanged and drives illegalEntry high for the following cycle.
- R3: A return request, with no entry request in the same cycle, whose target is less than or equal to the current level sets the level to the target at the next edge. A target above the current level leaves the level unchanged and drives illegalReturn high for the following cycle.
- R4: When entry and return are requested in the same cycle, only the entry is acted on: the return neither changes the level nor raises illegalReturn.
- R5: elReadback carries the level in bits [3:2], and every other bit reads as zero.
- R6: cfgWrData is stored into the configuration register (seen on cfgRegOut) at the next edge only when cfgWrEn is high and the current level is EL3. At any other level the write leaves the register unchanged.
- R7: isSecure is 1 at EL3. At EL0, EL1 and EL2 it is the inverse of configuration bit 0. protNs is always the inverse of isSecure.
- R8: protPriv is 1 for class 0 (cacheable), for class 5 (translation table walk) and for the unused codes 6 and 7, at every level and for reads and writes alike.
- R9: At EL1, EL2 and EL3, protPriv is 1 for every class. At EL0 it is 0 for class 1 (strict device, read or write), for class 4 (exclusive store to shareable memory), and for reads of class 2 (device gathering) and class 3 (normal non-cacheable).
- R10: At EL0, writes of class 2 (device gathering) and class 3 (normal non-cacheable) have protPriv 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| excEntryReq | input | 1 | Exception entry request |
| excEntryTgt | input | 2 | Entry target level |
| excRetReq | input | 1 | Exception return request |
| excRetTgt | input | 2 | Return target level |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrData | input | CFG_W | Configuration write value (bit 0 = non-secure select) |
| accClass | input | 3 | Access class of the current bus access |
| accIsWrite | input | 1 | 1 for a write access, 0 for a read |
| curEl | output | 2 | Current exception level |
| elReadback | output | READ_W | Read-only level readback |
| cfgRegOut | output | CFG_W | Configuration register contents |
| isSecure | output | 1 | Effective security state (1 = secure) |
| protPriv | output | 1 | AxPROT[0] privilege bit |
| protNs | output | 1 | AxPROT[1] non-secure bit |
| illegalEntry | output | 1 | Previous cycle carried a rejected entry |
| illegalReturn | output | 1 | Previous cycle carried a rejected return |

## Verification
The hardest state to reach is EL0, EL1 or EL2 with the non-secure bit set. To reach it, the stimulus must first write the configuration register while at EL3 and then return downward, because no write lands below EL3. The directed part of the stimulus does exactly this before it sweeps every access class in both directions at EL0. The random part biases returns so that the lower levels are revisited often, and it issues configuration writes that are ignored at non-EL3 levels.

// File: rtl/elsec_pkg.sv
package elsec_pkg;

  localparam logic [1:0] EL_TOP = 2'd3;

  typedef enum logic [2:0] {
    ACC_CACHE      = 3'd0,
    ACC_DEV_STRICT = 3'd1,
    ACC_DEV_GRE    = 3'd2,
    ACC_NORM_NC    = 3'd3,
    ACC_EXCL_SH    = 3'd4,
    ACC_WALK       = 3'd5
  } accClass_e;

  typedef struct packed {
    logic       loadEl;
    logic [1:0] nextEl;
    logic       flagEntry;
    logic       flagRet;
    logic       loadCfg;
  } ctlStrobe_t;

  function automatic logic privFor(logic [1:0] el, logic [2:0] cls, logic isWr);
    logic p;
    if (el != 2'd0) begin
      p = 1'b1;
    end else begin
      case (cls)
        ACC_DEV_STRICT: p = 1'b0;
        ACC_DEV_GRE:    p = isWr;
        ACC_NORM_NC:    p = isWr;
        ACC_EXCL_SH:    p = 1'b0;
        default:        p = 1'b1;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/elsec_ctrl.sv
module elsec_ctrl
  import elsec_pkg::*;
(
  input  logic [1:0] curEl,
  input  logic       excEntryReq,
  input  logic [1:0] excEntryTgt,
  input  logic       excRetReq,
  input  logic [1:0] excRetTgt,
  input  logic       cfgWrEn,
  output ctlStrobe_t strb
);

  logic entryOk;
  logic retOk;

  assign entryOk = (excEntryTgt >= curEl);
  assign retOk   = (excRetTgt <= curEl);

  always_comb begin
    strb = '0;
    strb.nextEl = curEl;
    if (excEntryReq) begin
      if (entryOk) begin
        strb.loadEl = 1'b1;
        strb.nextEl = excEntryTgt;
      end else begin
        strb.flagEntry = 1'b1;
      end
    end else if (excRetReq) begin
      if (retOk) begin
        strb.loadEl = 1'b1;
        strb.nextEl = excRetTgt;
      end else begin
        strb.flagRet = 1'b1;
      end
    end
    strb.loadCfg = cfgWrEn && (curEl == EL_TOP);
  end

endmodule

// File: rtl/elsec_dp.sv
module elsec_dp
  import elsec_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int READ_W = 64,
  parameter int EL_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [2:0]        accClass,
  input  logic              accIsWrite,
  output logic [1:0]        curEl,
  output logic [READ_W-1:0] elReadback,
  output logic [CFG_W-1:0]  cfgRegOut,
  output logic              isSecure,
  output logic              protPriv,
  output logic              protNs,
  output logic              illegalEntry,
  output logic              illegalReturn
);

  localparam int NS_POS = 0;

  logic [1:0]       elQ;
  logic [CFG_W-1:0] cfgQ;
  logic             illEQ;
  logic             illRQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elQ   <= EL_TOP;
      cfgQ  <= '0;
      illEQ <= 1'b0;
      illRQ <= 1'b0;
    end else begin
      if (strb.loadEl) elQ <= strb.nextEl;
      if (strb.loadCfg) cfgQ <= cfgWrData;
      illEQ <= strb.flagEntry;
      illRQ <= strb.flagRet;
    end
  end

  always_comb begin
    elReadback = '0;
    elReadback[EL_LSB +: 2] = elQ;
  end

  logic secureNow;
  assign secureNow = (elQ == EL_TOP) ? 1'b1 : ~cfgQ[NS_POS];

  assign curEl         = elQ;
  assign cfgRegOut     = cfgQ;
  assign isSecure      = secureNow;
  assign protNs        = ~secureNow;
  assign protPriv      = privFor(elQ, accClass, accIsWrite);
  assign illegalEntry  = illEQ;
  assign illegalReturn = illRQ;

endmodule

// File: rtl/elsec_tracker.sv
module elsec_tracker
  import elsec_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int READ_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excEntryReq,
  input  logic [1:0]        excEntryTgt,
  input  logic              excRetReq,
  input  logic [1:0]        excRetTgt,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [2:0]        accClass,
  input  logic              accIsWrite,
  output logic [1:0]        curEl,
  output logic [READ_W-1:0] elReadback,
  output logic [CFG_W-1:0]  cfgRegOut,
  output logic              isSecure,
  output logic              protPriv,
  output logic              protNs,
  output logic              illegalEntry,
  output logic              illegalReturn
);

  ctlStrobe_t strb;

  elsec_ctrl ctrl_i (
    .curEl       (curEl),
    .excEntryReq (excEntryReq),
    .excEntryTgt (excEntryTgt),
    .excRetReq   (excRetReq),
    .excRetTgt   (excRetTgt),
    .cfgWrEn     (cfgWrEn),
    .strb        (strb)
  );

  elsec_dp #(.CFG_W(CFG_W), .READ_W(READ_W), .EL_LSB(2)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgWrData     (cfgWrData),
    .accClass      (accClass),
    .accIsWrite    (accIsWrite),
    .curEl         (curEl),
    .elReadback    (elReadback),
    .cfgRegOut     (cfgRegOut),
    .isSecure      (isSecure),
    .protPriv      (protPriv),
    .protNs        (protNs),
    .illegalEntry  (illegalEntry),
    .illegalReturn (illegalReturn)
  );

endmodule

// File: rtl/elsec_chk.sv
module elsec_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             excEntryReq,
  input logic [1:0]       excEntryTgt,
  input logic             excRetReq,
  input logic [1:0]       excRetTgt,
  input logic             cfgWrEn,
  input logic [2:0]       accClass,
  input logic [1:0]       curEl,
  input logic [CFG_W-1:0] cfgRegOut,
  input logic             isSecure,
  input logic             protPriv,
  input logic             protNs,
  input logic             illegalEntry,
  input logic             illegalReturn
);

  // R1
  reset_top_level_chk: assert property (@(posedge clk)
    !rstN |=> (curEl == 2'd3) && !illegalEntry && !illegalReturn);

  // R2
  entry_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEntryReq && (excEntryTgt < curEl) |=> $stable(curEl) && illegalEntry);

  // R2
  entry_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEntryReq && (excEntryTgt >= curEl) |=> (curEl == $past(excEntryTgt)) && !illegalEntry);

  // R3
  return_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excEntryReq && excRetReq && (excRetTgt > curEl) |=> $stable(curEl) && illegalReturn);

  // R4
  entry_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    excEntryReq && excRetReq |=> !illegalReturn);

  // R6
  cfg_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && (curEl != 2'd3) |=> $stable(cfgRegOut));

  // R7
  top_secure_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curEl == 2'd3) |-> isSecure && !protNs);

  // R7
  lower_ns_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curEl != 2'd3) |-> (protNs == cfgRegOut[0]));

  // R8
  always_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accClass == 3'd0 || accClass == 3'd5) |-> protPriv);

  // R9
  upper_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curEl != 2'd0) |-> protPriv);

endmodule

bind elsec_tracker elsec_chk #(.CFG_W(CFG_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .excEntryReq   (excEntryReq),
  .excEntryTgt   (excEntryTgt),
  .excRetReq     (excRetReq),
  .excRetTgt     (excRetTgt),
  .cfgWrEn       (cfgWrEn),
  .accClass      (accClass),
  .curEl         (curEl),
  .cfgRegOut     (cfgRegOut),
  .isSecure      (isSecure),
  .protPriv      (protPriv),
  .protNs        (protNs),
  .illegalEntry  (illegalEntry),
  .illegalReturn (illegalReturn)
);

// File: tb/elsec_tracker_tb_top.sv
`timescale 1ns/1ps
module elsec_tracker_tb_top;

  localparam int CFG_W  = 32;
  localparam int READ_W = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              excEntryReq = 1'b0;
  logic [1:0]        excEntryTgt = '0;
  logic              excRetReq = 1'b0;
  logic [1:0]        excRetTgt = '0;
  logic              cfgWrEn = 1'b0;
  logic [CFG_W-1:0]  cfgWrData = '0;
  logic [2:0]        accClass = '0;
  logic              accIsWrite = 1'b0;
  logic [1:0]        curEl;
  logic [READ_W-1:0] elReadback;
  logic [CFG_W-1:0]  cfgRegOut;
  logic              isSecure;
  logic              protPriv;
  logic              protNs;
  logic              illegalEntry;
  logic              illegalReturn;

  always #5 clk = ~clk;

  elsec_tracker #(.CFG_W(CFG_W), .READ_W(READ_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .excEntryReq(excEntryReq), .excEntryTgt(excEntryTgt),
    .excRetReq(excRetReq), .excRetTgt(excRetTgt),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .accClass(accClass), .accIsWrite(accIsWrite),
    .curEl(curEl), .elReadback(elReadback), .cfgRegOut(cfgRegOut),
    .isSecure(isSecure), .protPriv(protPriv), .protNs(protNs),
    .illegalEntry(illegalEntry), .illegalReturn(illegalReturn)
  );

  int total = 0;
  int bad = 0;
  logic [1:0]       mEl = 2'd3;
  logic [CFG_W-1:0] mCfg = '0;
  logic             mIllE = 1'b0;
  logic             mIllR = 1'b0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expPriv(logic [1:0] el, logic [2:0] cls, logic wr);
    if (el != 2'd0) return 1'b1;
    if (cls == 3'd1 || cls == 3'd4) return 1'b0;
    if (cls == 3'd2 || cls == 3'd3) return wr;
    return 1'b1;
  endfunction

  function automatic logic expSecure(logic [1:0] el, logic [CFG_W-1:0] cfg);
    if (el == 2'd3) return 1'b1;
    return !cfg[0];
  endfunction

  task automatic checkState();
    logic [READ_W-1:0] rb;
    rb = '0;
    rb[3:2] = mEl;
    check("R2 R3 R4 level", {62'b0, curEl}, {62'b0, mEl});
    check("R5 readback", elReadback, rb);
    check("R6 cfg", {32'b0, cfgRegOut}, {32'b0, mCfg});
    check("R7 secure", {63'b0, isSecure}, {63'b0, expSecure(mEl, mCfg)});
    check("R7 ns", {63'b0, protNs}, {63'b0, !expSecure(mEl, mCfg)});
    check("R2 illegalEntry", {63'b0, illegalEntry}, {63'b0, mIllE});
    check("R3 R4 illegalReturn", {63'b0, illegalReturn}, {63'b0, mIllR});
  endtask

  task automatic step(logic e, logic [1:0] et, logic r, logic [1:0] rt,
                      logic w, logic [CFG_W-1:0] wd, logic [2:0] cls, logic wr);
    logic [1:0] nEl;
    logic fE;
    logic fR;
    @(negedge clk);
    checkState();
    excEntryReq = e; excEntryTgt = et;
    excRetReq = r;   excRetTgt = rt;
    cfgWrEn = w;     cfgWrData = wd;
    accClass = cls;  accIsWrite = wr;
    #1;
    if (cls == 3'd0 || cls >= 3'd5)
      check("R8 priv", {63'b0, protPriv}, {63'b0, expPriv(mEl, cls, wr)});
    else if (mEl == 2'd0 && wr && (cls == 3'd2 || cls == 3'd3))
      check("R10 priv", {63'b0, protPriv}, {63'b0, expPriv(mEl, cls, wr)});
    else
      check("R9 priv", {63'b0, protPriv}, {63'b0, expPriv(mEl, cls, wr)});
    nEl = mEl; fE = 1'b0; fR = 1'b0;
    if (e) begin
      if (et >= mEl) nEl = et; else fE = 1'b1;
    end else if (r) begin
      if (rt <= mEl) nEl = rt; else fR = 1'b1;
    end
    if (w && mEl == 2'd3) mCfg = wd;
    mEl = nEl; mIllE = fE; mIllR = fR;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    // R1: reset values
    repeat (2) @(negedge clk);
    check("R1 level", {62'b0, curEl}, 64'd3);
    check("R1 cfg", {32'b0, cfgRegOut}, 64'd0);
    check("R1 flags", {62'b0, illegalEntry, illegalReturn}, 64'd0);
    check("R1 secure", {63'b0, isSecure}, 64'd1);
    rstN = 1'b1;
    // R6: write NS at EL3, then drop to EL0
    step(0, 0, 0, 0, 1, 32'h0000_0001, 3'd0, 0);
    step(0, 0, 1, 2'd0, 0, 0, 3'd0, 0);
    // R6: write at EL0 ignored
    step(0, 0, 0, 0, 1, 32'h0000_00F0, 3'd1, 0);
    // R9 R10 sweep at EL0
    for (int c = 0; c < 8; c++) begin
      step(0, 0, 0, 0, 0, 0, c[2:0], 1'b0);
      step(0, 0, 0, 0, 0, 0, c[2:0], 1'b1);
    end
    // R3: illegal return upward, R2: legal entry to EL1
    step(0, 0, 1, 2'd2, 0, 0, 3'd3, 1);
    step(1, 2'd1, 0, 0, 0, 0, 3'd3, 1);
    // R2: illegal entry downward
    step(1, 2'd0, 0, 0, 0, 0, 3'd1, 0);
    // R4: entry and illegal return together
    step(1, 2'd2, 1, 2'd3, 0, 0, 3'd1, 0);
    // R4: illegal entry with legal return together
    step(1, 2'd0, 1, 2'd0, 0, 0, 3'd4, 1);
    step(1, 2'd3, 0, 0, 1, 32'hA5A5_0000, 3'd2, 0);
    step(0, 0, 0, 0, 0, 0, 3'd2, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, 2'($urandom),
           ($urandom % 3) == 0, 2'($urandom),
           ($urandom % 5) == 0, $urandom,
           3'($urandom), 1'($urandom));
    end
    @(negedge clk);
    checkState();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule